// File: doc/BRIEF.md
# Dual-Slot Integer/FP Issue Unit

This block is the issue stage of a statically paired dual-issue pipeline. Every clock, fetch presents a 64-bit packet made of two 32-bit instruction words: a lower (first) slot and an upper (second) slot. The unit decides whether to send both words, only the lower one, or nothing on to the execution pipes. A pair goes out together only when the lower word is bound for the integer side and the upper word is a floating-point operation. Both words then move through their five-stage pipes side by side.

When only the lower word can leave, the upper word is kept inside the unit and retried on its own in the cycles that follow. While a word is kept, or while a fresh packet cannot leave, the unit raises a hold signal back to fetch, and fetch keeps the packet steady. A pair made of a floating-point load in the lower slot and a floating-point operation in the upper slot is allowed, and it is flagged so that a second floating-point register-file write port can be claimed for it. Issue strobes and the issued words come from registers, one clock after the decision.

Top module: `iss_dual_issue`

## Requirements
- R1: Instruction class is taken from bits [31:29] of each word: 3'b110 is an FP operation, 3'b101 is an FP load, and any other value is integer class. A fresh packet whose lower word is not an FP operation, whose upper word is an FP operation, with `lo_stall`=0, `hi_hazard`=0 and `down_ready`=1, issues both words in one cycle.
- R2: The upper word never issues while a fresh lower word does not. An upper-only issue happens only for a word kept from an earlier packet, and only while `hold_fetch` was high in the deciding cycle.
- R3: When the lower word of a fresh packet issues but the packet is not such a pair (lower word is an FP operation, or upper word is not an FP operation, or `hi_hazard`=1), only the lower word issues. The upper word is kept and retried alone from the next cycle on.
- R4: While a word is kept, `hold_fetch` is 1 and `in_valid`, `in_packet` and `lo_stall` have no effect on what issues.
- R5: With `lo_stall`=1 or `down_ready`=0, a fresh packet issues nothing and `hold_fetch` is 1 in that cycle. With no kept word and `in_valid`=0, `hold_fetch` is 0.
- R6: A kept word waits while `hi_hazard`=1 or `down_ready`=0. It issues on `issue_hi` in the first cycle where both allow it, and `hold_fetch` drops in the cycle after that.
- R7: `fp_pair_extra_port` is 1 exactly for an issued pair whose lower word is an FP load.
- R8: Issue strobes and words are registered: they show the decision of the previous cycle. `issue_lo_instr` carries the lower word, and `issue_hi_instr` carries the upper word or the kept word.
- R9: A synchronous active-high `rst` discards any kept word and clears all issue strobes and `fp_pair_extra_port`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetch packet present |
| in_packet | input | 64 | Packet; lower word in [31:0], upper word in [63:32] |
| lo_stall | input | 1 | Lower-slot stall from the decoder; blocks both slots |
| hi_hazard | input | 1 | Hazard on the upper slot, or on the kept word |
| down_ready | input | 1 | Execution pipes can accept this cycle |
| hold_fetch | output | 1 | Fetch must keep its packet |
| issue_lo | output | 1 | Lower word issued |
| issue_lo_instr | output | 32 | Issued lower word |
| issue_hi | output | 1 | Upper or kept word issued |
| issue_hi_instr | output | 32 | Issued upper or kept word |
| fp_pair_extra_port | output | 1 | Issued pair needs a second FP write port |

## Verification
The bench walks a sequence through each way a pair can be refused: an FP operation in the lower slot, an FP load in the upper slot, and an upper-slot hazard. In each case it checks that only the lower word leaves and that the kept word comes out alone later. A design that let the upper word go with the wrong class would show a pair strobe where one strobe is expected, and a design that dropped the kept word would never raise `issue_hi` on the retry. The sequence also presents new packets while a word is kept, and a lower-slot stall together with a missing ready. A unit that took the new packet, or that leaked a half pair, would miscompare on `hold_fetch` or on the strobes. Reset arrives while a word is kept, and the bench checks the word of a kept-slot retry, so a stale word or a slot that survives reset shows up.

// File: rtl/iss_pkg.sv
package iss_pkg;

    localparam int WORD_W  = 32;
    localparam int SLOTS   = 2;
    localparam int CLS_W   = 3;
    localparam logic [CLS_W-1:0] CODE_FPOP = 3'b110;
    localparam logic [CLS_W-1:0] CODE_FPLD = 3'b101;

    typedef enum logic [1:0] {
        CLS_INT  = 2'd0,
        CLS_FPOP = 2'd1,
        CLS_FPLD = 2'd2
    } iclass_e;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } slot_t;

    function automatic iclass_e classify(input logic [WORD_W-1:0] w);
        logic [CLS_W-1:0] code;
        code = w[WORD_W-1 -: CLS_W];
        if (code == CODE_FPOP)      return CLS_FPOP;
        else if (code == CODE_FPLD) return CLS_FPLD;
        else                        return CLS_INT;
    endfunction

endpackage

// File: rtl/iss_classify.sv
module iss_classify
    import iss_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output iclass_e           cls
);
    always_comb cls = classify(word);
endmodule

// File: rtl/iss_pair_ctl.sv
module iss_pair_ctl
    import iss_pkg::*;
(
    input  logic    held_vld,
    input  logic    in_valid,
    input  iclass_e cls_lo,
    input  iclass_e cls_hi,
    input  logic    lo_stall,
    input  logic    hi_hazard,
    input  logic    down_ready,
    output logic    go_lo,
    output logic    go_pair,
    output logic    go_held,
    output logic    keep_hi,
    output logic    hold_fetch,
    output logic    extra_port
);
    logic fresh;
    logic pairable;

    always_comb begin
        fresh      = in_valid && !held_vld;
        go_lo      = fresh && !lo_stall && down_ready;
        pairable   = (cls_lo != CLS_FPOP) && (cls_hi == CLS_FPOP) && !hi_hazard;
        go_pair    = go_lo && pairable;
        keep_hi    = go_lo && !pairable;
        go_held    = held_vld && !hi_hazard && down_ready;
        hold_fetch = held_vld || (in_valid && !go_lo);
        extra_port = go_pair && (cls_lo == CLS_FPLD);
    end
endmodule

// File: rtl/iss_hold_reg.sv
module iss_hold_reg
    import iss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              keep_hi,
    input  logic              go_held,
    input  logic [WORD_W-1:0] hi_word,
    output slot_t             held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (keep_hi) begin
            held.vld  <= 1'b1;
            held.word <= hi_word;
        end else if (go_held) begin
            held.vld <= 1'b0;
        end
    end
endmodule

// File: rtl/iss_out_reg.sv
module iss_out_reg
    import iss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go_lo,
    input  logic              go_pair,
    input  logic              go_held,
    input  logic              extra_port,
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    input  logic [WORD_W-1:0] held_word,
    output slot_t             out_lo,
    output slot_t             out_hi,
    output logic              out_extra
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_lo    <= '0;
            out_hi    <= '0;
            out_extra <= 1'b0;
        end else begin
            out_lo.vld <= go_lo;
            if (go_lo) out_lo.word <= lo_word;
            out_hi.vld <= go_pair || go_held;
            if (go_held)      out_hi.word <= held_word;
            else if (go_pair) out_hi.word <= hi_word;
            out_extra <= extra_port;
        end
    end
endmodule

// File: rtl/iss_dual_issue.sv
module iss_dual_issue
    import iss_pkg::*;
#(
    parameter int INSTR_W = iss_pkg::WORD_W,
    localparam int PKT_W  = INSTR_W * iss_pkg::SLOTS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [PKT_W-1:0]   in_packet,
    input  logic               lo_stall,
    input  logic               hi_hazard,
    input  logic               down_ready,
    output logic               hold_fetch,
    output logic               issue_lo,
    output logic [INSTR_W-1:0] issue_lo_instr,
    output logic               issue_hi,
    output logic [INSTR_W-1:0] issue_hi_instr,
    output logic               fp_pair_extra_port
);
    iclass_e              cls [SLOTS];
    logic [INSTR_W-1:0]   words [SLOTS];
    slot_t                held;
    slot_t                out_lo;
    slot_t                out_hi;
    logic                 held_vld;
    logic                 go_lo, go_pair, go_held, keep_hi, extra_port;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign words[g] = in_packet[g*INSTR_W +: INSTR_W];
        iss_classify u_cls (
            .word (words[g]),
            .cls  (cls[g])
        );
    end

    assign held_vld = held.vld;

    iss_pair_ctl u_ctl (
        .held_vld   (held_vld),
        .in_valid   (in_valid),
        .cls_lo     (cls[0]),
        .cls_hi     (cls[1]),
        .lo_stall   (lo_stall),
        .hi_hazard  (hi_hazard),
        .down_ready (down_ready),
        .go_lo      (go_lo),
        .go_pair    (go_pair),
        .go_held    (go_held),
        .keep_hi    (keep_hi),
        .hold_fetch (hold_fetch),
        .extra_port (extra_port)
    );

    iss_hold_reg u_hold (
        .clk     (clk),
        .rst     (rst),
        .keep_hi (keep_hi),
        .go_held (go_held),
        .hi_word (words[1]),
        .held    (held)
    );

    iss_out_reg u_out (
        .clk        (clk),
        .rst        (rst),
        .go_lo      (go_lo),
        .go_pair    (go_pair),
        .go_held    (go_held),
        .extra_port (extra_port),
        .lo_word    (words[0]),
        .hi_word    (words[1]),
        .held_word  (held.word),
        .out_lo     (out_lo),
        .out_hi     (out_hi),
        .out_extra  (fp_pair_extra_port)
    );

    assign issue_lo       = out_lo.vld;
    assign issue_lo_instr = out_lo.word;
    assign issue_hi       = out_hi.vld;
    assign issue_hi_instr = out_hi.word;
endmodule

// File: rtl/iss_dual_issue_chk.sv
module iss_dual_issue_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic lo_stall,
    input logic hi_hazard,
    input logic down_ready,
    input logic hold_fetch,
    input logic issue_lo,
    input logic issue_hi,
    input logic fp_pair_extra_port,
    input logic held_vld
);
    assert_hi_needs_lo_R2: assert property (@(posedge clk) disable iff (rst)
        (issue_hi && !issue_lo) |-> $past(hold_fetch));

    assert_lo_only_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_lo && !issue_hi) |-> hold_fetch);

    assert_kept_holds_R4: assert property (@(posedge clk) disable iff (rst)
        held_vld |=> !issue_lo);

    assert_stall_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !held_vld && (lo_stall || !down_ready)) |=> (!issue_lo && !issue_hi));

    assert_kept_waits_R6: assert property (@(posedge clk) disable iff (rst)
        (held_vld && (hi_hazard || !down_ready)) |=> !issue_hi);

    assert_extra_pair_R7: assert property (@(posedge clk) disable iff (rst)
        fp_pair_extra_port |-> (issue_lo && issue_hi));

    assert_reset_clears_R9: assert property (@(posedge clk)
        $past(rst) |-> (!issue_lo && !issue_hi && !fp_pair_extra_port));
endmodule

bind iss_dual_issue iss_dual_issue_chk u_chk (
    .clk                (clk),
    .rst                (rst),
    .in_valid           (in_valid),
    .lo_stall           (lo_stall),
    .hi_hazard          (hi_hazard),
    .down_ready         (down_ready),
    .hold_fetch         (hold_fetch),
    .issue_lo           (issue_lo),
    .issue_hi           (issue_hi),
    .fp_pair_extra_port (fp_pair_extra_port),
    .held_vld           (held_vld)
);

// File: tb/iss_dual_issue_tb.sv
module iss_dual_issue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 18;

    localparam logic [31:0] W_INT  = 32'h0000_1111;
    localparam logic [31:0] W_FPA  = 32'hC000_2222;
    localparam logic [31:0] W_FPL  = 32'hA000_3333;
    localparam logic [31:0] W_INT2 = 32'h0000_7777;

    // {valid, lo_sel[1:0], hi_sel[1:0], stall, hazard, ready, e_hold, e_lo, e_hi, e_extra}
    // sel: 0 integer, 1 FP operation, 2 FP load, 3 second integer
    localparam logic [11:0] VEC [NROWS] = '{
        {1'b1, 2'd0, 2'd1, 3'b001, 4'b0110},  // pair R1
        {1'b1, 2'd2, 2'd1, 3'b001, 4'b0111},  // load+op pair R7
        {1'b1, 2'd0, 2'd3, 3'b001, 4'b0100},  // int+int R3
        {1'b1, 2'd0, 2'd1, 3'b001, 4'b1010},  // kept retried, packet ignored R4
        {1'b1, 2'd0, 2'd1, 3'b001, 4'b0110},
        {1'b1, 2'd0, 2'd1, 3'b101, 4'b1000},  // lo stall R5
        {1'b1, 2'd0, 2'd1, 3'b001, 4'b0110},
        {1'b1, 2'd0, 2'd1, 3'b011, 4'b0100},  // hi hazard R3
        {1'b1, 2'd0, 2'd1, 3'b011, 4'b1000},  // kept waits on hazard R6
        {1'b1, 2'd0, 2'd1, 3'b000, 4'b1000},  // kept waits on ready R6
        {1'b1, 2'd0, 2'd1, 3'b001, 4'b1010},
        {1'b0, 2'd0, 2'd1, 3'b001, 4'b0000},  // idle R5
        {1'b1, 2'd1, 2'd1, 3'b001, 4'b0100},  // FP op in lower slot R3
        {1'b0, 2'd0, 2'd0, 3'b001, 4'b1010},
        {1'b1, 2'd0, 2'd2, 3'b001, 4'b0100},  // FP load in upper slot R3
        {1'b0, 2'd0, 2'd0, 3'b000, 4'b1000},
        {1'b0, 2'd0, 2'd0, 3'b001, 4'b1010},
        {1'b1, 2'd0, 2'd1, 3'b000, 4'b1000}   // no ready R5
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, lo_stall, hi_hazard, down_ready;
    logic [63:0] in_packet;
    logic        hold_fetch, issue_lo, issue_hi, fp_pair_extra_port;
    logic [31:0] issue_lo_instr, issue_hi_instr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iss_dual_issue u_dut (
        .clk                (clk),
        .rst                (rst),
        .in_valid           (in_valid),
        .in_packet          (in_packet),
        .lo_stall           (lo_stall),
        .hi_hazard          (hi_hazard),
        .down_ready         (down_ready),
        .hold_fetch         (hold_fetch),
        .issue_lo           (issue_lo),
        .issue_lo_instr     (issue_lo_instr),
        .issue_hi           (issue_hi),
        .issue_hi_instr     (issue_hi_instr),
        .fp_pair_extra_port (fp_pair_extra_port)
    );

    function automatic logic [31:0] pick(input logic [1:0] s);
        case (s)
            2'd0: return W_INT;
            2'd1: return W_FPA;
            2'd2: return W_FPL;
            default: return W_INT2;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_packet = '0;
        lo_stall = 1'b0; hi_hazard = 1'b0; down_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R9 reset hold_fetch", 32'(hold_fetch), 32'd0);
        check("R9 reset issue_lo", 32'(issue_lo), 32'd0);
        check("R9 reset issue_hi", 32'(issue_hi), 32'd0);

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            in_valid   = VEC[i][11];
            in_packet  = {pick(VEC[i][8:7]), pick(VEC[i][10:9])};
            lo_stall   = VEC[i][6];
            hi_hazard  = VEC[i][5];
            down_ready = VEC[i][4];
            #1;
            check($sformatf("R4/R5 row %0d hold_fetch", i), 32'(hold_fetch), 32'(VEC[i][3]));
            @(posedge clk);
            #1;
            check($sformatf("R1/R3/R6 row %0d issue_lo", i), 32'(issue_lo), 32'(VEC[i][2]));
            check($sformatf("R2/R3/R6 row %0d issue_hi", i), 32'(issue_hi), 32'(VEC[i][1]));
            check($sformatf("R7 row %0d extra port", i), 32'(fp_pair_extra_port), 32'(VEC[i][0]));
        end

        // R8: words travel with strobes, kept word comes out on the upper port
        @(negedge clk);
        in_valid = 1'b1; in_packet = {W_INT2, W_INT}; lo_stall = 1'b0;
        hi_hazard = 1'b0; down_ready = 1'b1;
        @(posedge clk); #1;
        check("R8 lower word", issue_lo_instr, W_INT);
        check("R3 lower only", 32'(issue_hi), 32'd0);
        @(negedge clk);
        in_packet = {W_FPA, W_FPL};
        @(posedge clk); #1;
        check("R8 kept word out", issue_hi_instr, W_INT2);
        check("R4 new packet not issued", 32'(issue_lo), 32'd0);
        @(negedge clk);
        in_packet = {W_FPA, W_INT};
        @(posedge clk); #1;
        check("R8 pair upper word", issue_hi_instr, W_FPA);
        check("R8 pair lower word", issue_lo_instr, W_INT);

        // R9: reset while a word is kept
        @(negedge clk);
        in_packet = {W_INT2, W_INT};
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(posedge clk); #1;
        check("R9 strobes after reset lo", 32'(issue_lo), 32'd0);
        check("R9 strobes after reset hi", 32'(issue_hi), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R9 kept word discarded", 32'(hold_fetch), 32'd0);
        @(posedge clk); #1;
        check("R9 no retry after reset", 32'(issue_hi), 32'd0);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule